// File: doc/BRIEF.md
# Multiplexed Program-Bus Fetch Monitor

This block listens, without ever driving anything, to the external program-memory bus of a small 8-bit controller. On that bus the low half of each fetch address and the instruction byte travel over the same eight lines at different times. A fast system clock oversamples the address-strobe line, the active-low program-read strobe, the eight shared lines, four dedicated upper address lines and one optional bank line. From these samples the block rebuilds every fetch as an address/byte pair.

When the address strobe falls, a new fetch address is taken. The low byte comes from the shared lines and the upper bits come from the dedicated lines. When the read strobe rises, the byte on the shared lines is taken as the fetched value. Each fetch is reported in two ways. The first is a one-cycle parallel record. The second is a three-byte stream with a valid/ready handshake, which suits a trace buffer or a serial uplink. Read strobes that arrive before any address strobe has fallen produce nothing.

Top module: `fetch_snoop`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rec_valid`, `st_valid` and `st_overflow` are all low.
- R2: A falling edge on `bus_ale` latches a fetch address. Bits 7:0 come from `bus_ad` and bits 11:8 come from `bus_ahi`, both as sampled with that falling edge.
- R3: With `bank_en` high, address bit 12 is the value of `bus_bank` sampled at the `bus_ale` fall. With `bank_en` low, bit 12 is 0.
- R4: A rising edge on `bus_psen_n` produces exactly one record: `rec_valid` is high for a single cycle, `rec_data` holds `bus_ad` sampled at that edge, and `rec_addr` holds the latest latched address. The pulse appears within five clock cycles of the edge.
- R5: After reset, rising edges on `bus_psen_n` produce no record until at least one `bus_ale` fall has been seen.
- R6: If a `bus_ale` fall and a `bus_psen_n` rise land in the same sample, the record carries the address latched by that same fall.
- R7: Each accepted record leaves the stream as three bytes, in this order: {3'b000, addr[12:8]}, then addr[7:0], then the data byte. A byte is transferred in any cycle where `st_valid` and `st_ready` are both high.
- R8: While `st_valid` is high and `st_ready` is low, `st_valid` stays high and `st_data` does not change.
- R9: A record that arrives while any byte of the previous record is still pending in the stream is left out of the stream, and `st_overflow` is set. It then stays set until reset. The pending record still completes, and the parallel record output is not affected.
- R10: A `bus_ale` fall with no following `bus_psen_n` rise produces no record. When several falls come before a rise, the rise uses the address from the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en | input | 1 | Use `bus_bank` as address bit 12 |
| bus_ale | input | 1 | Address strobe; a falling edge marks a new address |
| bus_psen_n | input | 1 | Active-low program read strobe; a rising edge marks the data |
| bus_ad | input | 8 | Shared address-low / data lines |
| bus_ahi | input | 4 | Upper address lines 11:8 |
| bus_bank | input | 1 | Optional bank line (address bit 12) |
| rec_valid | output | 1 | One-cycle pulse per fetch record |
| rec_addr | output | 13 | Fetch address of the record |
| rec_data | output | 8 | Fetched byte of the record |
| st_valid | output | 1 | Stream byte available |
| st_data | output | 8 | Stream byte |
| st_ready | input | 1 | Stream consumer accepts the byte |
| st_overflow | output | 1 | Sticky flag: a record was dropped from the stream |

## Verification
Two of the block's functions can fall in the same cycle: latching an address and capturing a byte. If a strobe fall and a read rise reach the synchronizer together, both must act, and the address update must win. The bench provokes this by changing both strobe lines at one clock edge, so that they enter the same sample. The record must then carry that fall's address, and its low byte must equal the data byte. A second collision is a new record arriving while the stream is stalled. This is provoked by holding `st_ready` low. The bench then checks that the old three bytes are delivered intact and that the overflow flag rises and stays set.

// File: rtl/fsnoop_pkg.sv
package fsnoop_pkg;
  localparam int LANE_W  = 8;
  localparam int UPPER_W = 4;
  localparam int ADDR_W  = LANE_W + UPPER_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LANE_W-1:0] data;
  } fetch_rec_t;
endpackage

// File: rtl/fsnoop_sync.sv
module fsnoop_sync #(
  parameter int W      = 15,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fsnoop_capture.sv
module fsnoop_capture
  import fsnoop_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int UW = UPPER_W,
  parameter int AW = LW + UW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_en,
  input  logic          s_ale,
  input  logic          s_psen_n,
  input  logic [LW-1:0] s_ad,
  input  logic [UW-1:0] s_ahi,
  input  logic          s_bank,
  output logic          rec_valid,
  output logic [AW-1:0] rec_addr,
  output logic [LW-1:0] rec_data
);
  logic          prev_ale, prev_psen;
  logic          armed_q;
  logic [AW-1:0] addr_q, addr_now;
  logic          ale_fall, psen_rise, arm_now, take;

  assign ale_fall  = prev_ale & ~s_ale;
  assign psen_rise = ~prev_psen & s_psen_n;

  // a fall in this sample takes effect before the capture of the same sample
  always_comb begin
    addr_now = addr_q;
    if (ale_fall) addr_now = {bank_en & s_bank, s_ahi, s_ad};
    arm_now = armed_q | ale_fall;
    take    = psen_rise & arm_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ale  <= 1'b0;
      prev_psen <= 1'b1;
      armed_q   <= 1'b0;
      addr_q    <= '0;
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      rec_data  <= '0;
    end else begin
      prev_ale  <= s_ale;
      prev_psen <= s_psen_n;
      armed_q   <= arm_now;
      addr_q    <= addr_now;
      rec_valid <= take;
      if (take) begin
        rec_addr <= addr_now;
        rec_data <= s_ad;
      end
    end
  end
endmodule

// File: rtl/fsnoop_serializer.sv
module fsnoop_serializer
  import fsnoop_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rec_valid,
  input  logic [AW-1:0] rec_addr,
  input  logic [LW-1:0] rec_data,
  input  logic          st_ready,
  output logic          st_valid,
  output logic [LW-1:0] st_data,
  output logic          st_overflow
);
  logic [LW-1:0] nxt1, nxt2;
  logic [1:0]    left;
  logic [LW-1:0] hi_byte;

  assign hi_byte = LW'(rec_addr >> LW);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid    <= 1'b0;
      st_data     <= '0;
      nxt1        <= '0;
      nxt2        <= '0;
      left        <= '0;
      st_overflow <= 1'b0;
    end else if (!st_valid) begin
      if (rec_valid) begin
        st_valid <= 1'b1;
        st_data  <= hi_byte;
        nxt1     <= rec_addr[LW-1:0];
        nxt2     <= rec_data;
        left     <= 2'd2;
      end
    end else begin
      if (rec_valid) st_overflow <= 1'b1;
      if (st_ready) begin
        if (left != 2'd0) begin
          st_data <= nxt1;
          nxt1    <= nxt2;
          left    <= left - 2'd1;
        end else begin
          st_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fetch_snoop.sv
module fetch_snoop
  import fsnoop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LW          = LANE_W,
  parameter int UW          = UPPER_W,
  parameter int AW          = LW + UW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_en,
  input  logic          bus_ale,
  input  logic          bus_psen_n,
  input  logic [LW-1:0] bus_ad,
  input  logic [UW-1:0] bus_ahi,
  input  logic          bus_bank,
  output logic          rec_valid,
  output logic [AW-1:0] rec_addr,
  output logic [LW-1:0] rec_data,
  output logic          st_valid,
  output logic [LW-1:0] st_data,
  input  logic          st_ready,
  output logic          st_overflow
);
  localparam int SYNC_W = 3 + LW + UW;

  logic [SYNC_W-1:0] raw, smp;

  assign raw = {bus_bank, bus_ahi, bus_ad, bus_psen_n, bus_ale};

  fsnoop_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (smp)
  );

  fsnoop_capture #(.LW(LW), .UW(UW), .AW(AW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .bank_en   (bank_en),
    .s_ale     (smp[0]),
    .s_psen_n  (smp[1]),
    .s_ad      (smp[2 +: LW]),
    .s_ahi     (smp[2+LW +: UW]),
    .s_bank    (smp[SYNC_W-1]),
    .rec_valid (rec_valid),
    .rec_addr  (rec_addr),
    .rec_data  (rec_data)
  );

  fsnoop_serializer #(.LW(LW), .AW(AW)) u_ser (
    .clk         (clk),
    .rst         (rst),
    .rec_valid   (rec_valid),
    .rec_addr    (rec_addr),
    .rec_data    (rec_data),
    .st_ready    (st_ready),
    .st_valid    (st_valid),
    .st_data     (st_data),
    .st_overflow (st_overflow)
  );
endmodule

// File: rtl/fsnoop_chk.sv
module fsnoop_chk #(
  parameter int LW = 8,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          rec_valid,
  input logic [AW-1:0] rec_addr,
  input logic          st_valid,
  input logic [LW-1:0] st_data,
  input logic          st_ready,
  input logic          st_overflow
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rec_valid && !st_valid && !st_overflow));

  // R4
  rec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  // R7
  first_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !st_valid) |=> (st_valid && st_data == LW'($past(rec_addr) >> LW)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && st_valid) |=> st_overflow);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    st_overflow |=> st_overflow);
endmodule

bind fetch_snoop fsnoop_chk #(.LW(LW), .AW(AW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rec_valid   (rec_valid),
  .rec_addr    (rec_addr),
  .st_valid    (st_valid),
  .st_data     (st_data),
  .st_ready    (st_ready),
  .st_overflow (st_overflow)
);

// File: tb/fetch_snoop_tb_top.sv
module fetch_snoop_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_en = 1'b0;
  logic        bus_ale = 1'b0;
  logic        bus_psen_n = 1'b1;
  logic [7:0]  bus_ad = '0;
  logic [3:0]  bus_ahi = '0;
  logic        bus_bank = 1'b0;
  logic        rec_valid;
  logic [12:0] rec_addr;
  logic [7:0]  rec_data;
  logic        st_valid;
  logic [7:0]  st_data;
  logic        st_ready = 1'b1;
  logic        st_overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [20:0] rec_q[$];
  logic [7:0]  st_q[$];

  always #2.5 clk = ~clk;

  fetch_snoop dut_i (
    .clk(clk), .rst(rst), .bank_en(bank_en),
    .bus_ale(bus_ale), .bus_psen_n(bus_psen_n), .bus_ad(bus_ad),
    .bus_ahi(bus_ahi), .bus_bank(bus_bank),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data),
    .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready),
    .st_overflow(st_overflow)
  );

  // monitors sample 1 ns before each rising edge
  always begin
    @(negedge clk);
    #1.5;
    if (!rst && rec_valid) rec_q.push_back({rec_addr, rec_data});
    if (!rst && st_valid && st_ready) st_q.push_back(st_data);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    rec_q.delete();
    st_q.delete();
  endtask

  task automatic put_addr(input logic [12:0] a);
    bus_ad = a[7:0]; bus_ahi = a[11:8]; bus_bank = a[12];
  endtask

  task automatic ale_pulse(input logic [12:0] a);
    put_addr(a);
    bus_ale = 1'b1; cyc(3);
    bus_ale = 1'b0; cyc(3);
  endtask

  task automatic psen_pulse(input logic [7:0] d);
    bus_ad = d;
    bus_psen_n = 1'b0; cyc(3);
    bus_psen_n = 1'b1; cyc(10);
  endtask

  task automatic expect_record(input string req, input logic [12:0] ea, input logic [7:0] ed);
    logic [20:0] r;
    chk(rec_q.size() == 1, req, "record count", rec_q.size(), 1);
    if (rec_q.size() > 0) begin
      r = rec_q.pop_front();
      chk(r[20:8] == ea, req, "address", r[20:8], ea);
      chk(r[7:0] == ed, req, "data", r[7:0], ed);
    end
    rec_q.delete();
  endtask

  task automatic expect_stream(input string req, input logic [12:0] ea, input logic [7:0] ed);
    logic [7:0] b;
    chk(st_q.size() == 3, req, "stream byte count", st_q.size(), 3);
    if (st_q.size() == 3) begin
      b = st_q.pop_front(); chk(b == {3'b000, ea[12:8]}, req, "high byte", b, {3'b000, ea[12:8]});
      b = st_q.pop_front(); chk(b == ea[7:0], req, "low byte", b, ea[7:0]);
      b = st_q.pop_front(); chk(b == ed, req, "data byte", b, ed);
    end
    st_q.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rec_valid && !st_valid && !st_overflow, "R1", "outputs in reset",
        {rec_valid, st_valid, st_overflow}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rec_valid && !st_valid && !st_overflow, "R1", "outputs after release",
        {rec_valid, st_valid, st_overflow}, 0);
  endtask

  task automatic t_pre_arm();
    for (int i = 0; i < 3; i++) psen_pulse(8'(i * 37 + 5));
    chk(rec_q.size() == 0, "R5", "records before first address strobe", rec_q.size(), 0);
    chk(st_q.size() == 0, "R5", "stream bytes before first address strobe", st_q.size(), 0);
  endtask

  task automatic t_fetch_random(input bit use_bank);
    bank_en = use_bank;
    for (int i = 0; i < 8; i++) begin
      logic [12:0] a;
      logic [12:0] ea;
      logic [7:0]  d;
      a = 13'($urandom);
      d = 8'($urandom);
      if (i == 0) a[12] = 1'b1;
      ea = {use_bank & a[12], a[11:0]};
      ale_pulse(a);
      psen_pulse(d);
      expect_record(use_bank ? "R3" : "R2", ea, d);
      expect_record_dummy();
      expect_stream("R7", ea, d);
    end
  endtask

  task automatic expect_record_dummy();
    chk(rec_q.size() == 0, "R4", "single record per read strobe", rec_q.size(), 0);
  endtask

  task automatic t_multi_ale();
    bank_en = 1'b1;
    ale_pulse(13'h0A5C);
    cyc(10);
    chk(rec_q.size() == 0, "R10", "record from strobe without read", rec_q.size(), 0);
    ale_pulse(13'h1F31);
    psen_pulse(8'hC4);
    expect_record("R10", 13'h1F31, 8'hC4);
    expect_stream("R10", 13'h1F31, 8'hC4);
  endtask

  task automatic t_coincident(input logic [12:0] a);
    bank_en = 1'b1;
    @(negedge clk);
    put_addr(a);
    bus_ale = 1'b1; bus_psen_n = 1'b0;
    cyc(3);
    bus_ale = 1'b0; bus_psen_n = 1'b1;
    cyc(10);
    expect_record("R6", a, a[7:0]);
    expect_stream("R6", a, a[7:0]);
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    bank_en = 1'b0;
    st_ready = 1'b0;
    ale_pulse(13'h0321);
    psen_pulse(8'h9E);
    expect_record("R4", 13'h0321, 8'h9E);
    held = st_data;
    chk(st_valid && held == 8'h03, "R8", "first byte waiting", held, 8'h03);
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk(st_valid && st_data == held, "R8", "byte held under stall", st_data, held);
    end
    chk(!st_overflow, "R9", "no overflow before second record", st_overflow, 0);
    ale_pulse(13'h0777);
    psen_pulse(8'h11);
    expect_record("R9", 13'h0777, 8'h11);
    chk(st_overflow, "R9", "overflow after dropped record", st_overflow, 1);
    st_ready = 1'b1;
    cyc(8);
    expect_stream("R9", 13'h0321, 8'h9E);
    chk(!st_valid, "R9", "dropped record not streamed", st_valid, 0);
    chk(st_overflow, "R9", "overflow sticky", st_overflow, 1);
    do_reset();
    @(negedge clk);
    chk(!st_overflow, "R1", "overflow cleared by reset", st_overflow, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_pre_arm();
    t_fetch_random(1'b0);
    t_fetch_random(1'b1);
    t_multi_ale();
    t_coincident(13'h1ABC);
    t_coincident(13'h0E07);
    t_backpressure();
    do_reset();
    t_pre_arm();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule